// File: doc/BRIEF.md
# Synchronous Burst Read Timing Controller

This block sits on the memory side of a synchronous burst read path. A single-clock strobe with a start address begins a burst. After a programmable first-access latency the block puts one word per beat on its data bus, and it reads those words from a behavioural storage array at sequential addresses. A WAIT pin tells the host, clock by clock, whether the bus carries valid data. Each word is held for either one or two clocks.

A small configuration register sets the WAIT pin's active level and its timing. In coincident mode WAIT is asserted in the same clocks in which data is invalid. In early mode it is asserted one beat ahead of them. The register is written through a plain write port and can be read back. The block copies it into an active set only when a burst is accepted, so a write never disturbs a burst that is in flight. A burst that steps onto an aligned 16-word boundary gets one extra wait beat before the word at that boundary.

Top module: `burst_read_timer`

## Requirements
- R1: The configuration register resets to 7'h42 and reads back as {1'b1, pol, early, hold2, lat[2:0]}. Bit 6 is the burst-type flag and always reads 1. A write sets bits 5:0 from cfg_wdata[5:0].
- R2: Register writes take effect only when the next burst is accepted. A write made while idle or during a burst does not change the WAIT level, the hold or the timing of the current or idle period.
- R3: A burst is accepted when burst_start is high at a clock edge while the block is idle. The first valid word appears in clock L+1 after that edge. L is the lat field, and a field value of 0 means 8.
- R4: Words come from sequential addresses that start at burst_addr and wrap modulo 64. The word at address a is the low 16 bits of (a*40503) XOR 16'h5A3C. rd_data is 0 whenever data_vld is low.
- R5: With hold2=1, each word and each boundary wait beat lasts two clocks. With hold2=0, each lasts one clock.
- R6: Before any word other than the first whose address is a multiple of 16, exactly one wait beat is inserted.
- R7: With pol=1, WAIT is active high. With pol=0, WAIT is active low.
- R8: With early=0 during a burst, WAIT is asserted exactly in the clocks where data_vld is low.
- R9: With early=1 during a burst, WAIT in clock t is asserted exactly when clock t+H is still inside the burst and carries no valid data. H is the beat length in clocks.
- R10: When no burst is active, data_vld is 0 and WAIT sits at its inactive level.
- R11: A burst delivers exactly 8 words and then returns to idle. burst_start is ignored while a burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 7 | Configuration write data (bits 5:0 used) |
| cfg_rdata | output | 7 | Configuration readback, bit 6 fixed at 1 |
| burst_start | input | 1 | Burst request strobe |
| burst_addr | input | 6 | Burst start address |
| rd_data | output | 16 | Burst data word |
| data_vld | output | 1 | Data word valid in this clock |
| wait_o | output | 1 | WAIT indicator, configurable polarity and timing |

## Verification
The checker watches four things on every clock:
- the fixed burst-type readback bit;
- the idle WAIT level and the cleared valid state;
- the equality of WAIT and invalid data in coincident mode;
- the zero data bus while invalid, the frozen active configuration during a burst, and the two-clock stability of a word in hold mode.

The look-ahead of early mode, the latency count, boundary insertion, the address and data sequence, burst length and the ignoring of a mid-burst strobe depend on the whole timeline of a burst. Only the bench can show these. It compares every clock of every burst against a timeline built arithmetically from the requirements.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int LAT_W = 3;
    localparam int CFG_W = 7;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LAT,
        PH_DATA,
        PH_GAP
    } phase_e;

    // bits 5:0 of the register, MSB first
    typedef struct packed {
        logic             pol;
        logic             early;
        logic             hold2;
        logic [LAT_W-1:0] lat;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{pol: 1'b0, early: 1'b0, hold2: 1'b0, lat: 3'd2};

endpackage

// File: rtl/burst_cfg.sv
module burst_cfg
    import burst_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    input  logic             accept,
    output cfg_t             pend,
    output cfg_t             active,
    output logic [CFG_W-1:0] rd_data
);

    typedef struct packed {
        cfg_t pend;
        cfg_t active;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            r_d.pend = cfg_t'(wr_data[CFG_W-2:0]);
        end
        // the active copy only changes when a burst is accepted
        if (accept) begin
            r_d.active = r_q.pend;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{pend: CFG_RESET, active: CFG_RESET};
        end else begin
            r_q <= r_d;
        end
    end

    assign pend    = r_q.pend;
    assign active  = r_q.active;
    assign rd_data = {1'b1, r_q.pend};

endmodule

// File: rtl/burst_store.sv
module burst_store #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] word
);

    localparam int DEPTH = 1 << AW;

    function automatic logic [DW-1:0] fill(input int idx);
        logic [31:0] p;
        p = (32'(idx) * 32'd40503) ^ 32'h0000_5A3C;
        return p[DW-1:0];
    endfunction

    logic [DW-1:0] cells [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        assign cells[i] = fill(i);
    end

    assign word = cells[addr];

endmodule

// File: rtl/burst_seq.sv
module burst_seq
    import burst_pkg::*;
#(
    parameter int AW     = 6,
    parameter int BEATS  = 8,
    parameter int BND_LG = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [AW-1:0]    start_addr,
    input  logic [LAT_W-1:0] lat_field,
    input  logic             hold2,
    output logic             accept,
    output phase_e           phase,
    output logic [AW-1:0]    addr,
    output logic             gap_ahead,
    output logic             lat_ahead
);

    localparam int CNT_W  = LAT_W + 1;
    localparam int LEFT_W = $clog2(BEATS + 1);

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  lat;
        logic              ph;
        logic [AW-1:0]     addr;
        logic [LEFT_W-1:0] left;
    } seq_t;

    seq_t s_d, s_q;

    logic             slot_end;
    logic             at_edge;
    logic [CNT_W-1:0] beat_len;

    assign slot_end = !hold2 || s_q.ph;
    assign at_edge  = &s_q.addr[BND_LG-1:0];
    assign beat_len = hold2 ? CNT_W'(2) : CNT_W'(1);
    assign accept   = start && (s_q.phase == PH_IDLE);

    always_comb begin
        s_d = s_q;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (start) begin
                    s_d.phase = PH_LAT;
                    s_d.lat   = (lat_field == '0) ? CNT_W'(1 << LAT_W) : CNT_W'(lat_field);
                    s_d.addr  = start_addr;
                    s_d.left  = LEFT_W'(BEATS);
                    s_d.ph    = 1'b0;
                end
            end
            PH_LAT: begin
                if (s_q.lat == CNT_W'(1)) begin
                    s_d.phase = PH_DATA;
                    s_d.ph    = 1'b0;
                end else begin
                    s_d.lat = s_q.lat - CNT_W'(1);
                end
            end
            PH_DATA: begin
                if (slot_end) begin
                    s_d.ph = 1'b0;
                    if (s_q.left == LEFT_W'(1)) begin
                        s_d.phase = PH_IDLE;
                    end else begin
                        s_d.addr  = s_q.addr + AW'(1);
                        s_d.left  = s_q.left - LEFT_W'(1);
                        s_d.phase = at_edge ? PH_GAP : PH_DATA;
                    end
                end else begin
                    s_d.ph = 1'b1;
                end
            end
            PH_GAP: begin
                if (slot_end) begin
                    s_d.phase = PH_DATA;
                    s_d.ph    = 1'b0;
                end else begin
                    s_d.ph = 1'b1;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, lat: '0, ph: 1'b0, addr: '0, left: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign phase     = s_q.phase;
    assign addr      = s_q.addr;
    assign gap_ahead = (s_q.phase == PH_DATA) && (s_q.left > LEFT_W'(1)) && at_edge;
    assign lat_ahead = (s_q.phase == PH_LAT) && (s_q.lat > beat_len);

endmodule

// File: rtl/burst_wait.sv
module burst_wait (
    input  logic busy,
    input  logic vld,
    input  logic lat_ahead,
    input  logic gap_ahead,
    input  logic early,
    input  logic pol,
    output logic wait_pin
);

    logic act;

    always_comb begin
        if (early) begin
            act = lat_ahead || gap_ahead;
        end else begin
            act = busy && !vld;
        end
        wait_pin = pol ? act : !act;
    end

endmodule

// File: rtl/burst_read_timer.sv
module burst_read_timer
    import burst_pkg::*;
#(
    parameter int AW     = 6,
    parameter int DW     = 16,
    parameter int BEATS  = 8,
    parameter int BND_LG = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             burst_start,
    input  logic [AW-1:0]    burst_addr,
    output logic [DW-1:0]    rd_data,
    output logic             data_vld,
    output logic             wait_o
);

    cfg_t          cfg_pend;
    cfg_t          cfg_act;
    logic          accept;
    phase_e        phase;
    logic [AW-1:0] cur_addr;
    logic          gap_ahead;
    logic          lat_ahead;
    logic          seq_busy;
    logic [DW-1:0] word;

    burst_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .accept  (accept),
        .pend    (cfg_pend),
        .active  (cfg_act),
        .rd_data (cfg_rdata)
    );

    // latency is taken from the pending value, which becomes active at the same edge
    burst_seq #(.AW(AW), .BEATS(BEATS), .BND_LG(BND_LG)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (burst_start),
        .start_addr (burst_addr),
        .lat_field  (cfg_pend.lat),
        .hold2      (cfg_act.hold2),
        .accept     (accept),
        .phase      (phase),
        .addr       (cur_addr),
        .gap_ahead  (gap_ahead),
        .lat_ahead  (lat_ahead)
    );

    burst_store #(.AW(AW), .DW(DW)) u_store (
        .addr (cur_addr),
        .word (word)
    );

    assign seq_busy = (phase != PH_IDLE);
    assign data_vld = (phase == PH_DATA);
    assign rd_data  = data_vld ? word : '0;

    burst_wait u_wait (
        .busy      (seq_busy),
        .vld       (data_vld),
        .lat_ahead (lat_ahead),
        .gap_ahead (gap_ahead),
        .early     (cfg_act.early),
        .pol       (cfg_act.pol),
        .wait_pin  (wait_o)
    );

endmodule

// File: rtl/burst_read_timer_chk.sv
module burst_read_timer_chk
    import burst_pkg::*;
#(
    parameter int DW = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             data_vld,
    input logic             wait_o,
    input logic [DW-1:0]    rd_data,
    input logic [CFG_W-1:0] cfg_rdata,
    input cfg_t             active
);

    p_type_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[CFG_W-1] == 1'b1);

    p_frozen_cfg_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(active));

    p_zero_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !data_vld |-> rd_data == '0);

    p_hold_two_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy && active.hold2 && $rose(data_vld) |=> data_vld && $stable(rd_data));

    p_coincident_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !active.early |-> ((wait_o == active.pol) == !data_vld));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !data_vld && (wait_o == !active.pol));

endmodule

bind burst_read_timer burst_read_timer_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (seq_busy),
    .data_vld  (data_vld),
    .wait_o    (wait_o),
    .rd_data   (rd_data),
    .cfg_rdata (cfg_rdata),
    .active    (cfg_act)
);

// File: tb/sim_burst_read_timer.sv
`timescale 1ns/1ps
module sim_burst_read_timer;

    localparam int AW    = 6;
    localparam int DW    = 16;
    localparam int BEATS = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [6:0]    cfg_wdata = '0;
    logic [6:0]    cfg_rdata;
    logic          burst_start = 1'b0;
    logic [AW-1:0] burst_addr = '0;
    logic [DW-1:0] rd_data;
    logic          data_vld;
    logic          wait_o;

    int nvec = 0;
    int nerr = 0;

    int ev [0:63];
    int ea [0:63];
    int tend;

    always #5 clk = ~clk;

    burst_read_timer u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .burst_start (burst_start),
        .burst_addr  (burst_addr),
        .rd_data     (rd_data),
        .data_vld    (data_vld),
        .wait_o      (wait_o)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        nvec++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
        end
    endtask

    function automatic logic [15:0] wordf(input int a);
        logic [31:0] p;
        p = (32'(a) * 32'd40503) ^ 32'h5A3C;
        return p[15:0];
    endfunction

    function automatic logic [6:0] cfg_of(input int n);
        int latv [4] = '{1, 2, 5, 0};
        int lat   = latv[n % 4];
        int hold  = (n / 4) % 2;
        int early = (n / 8) % 2;
        int pol   = (n / 16) % 2;
        return 7'(pol * 32 + early * 16 + hold * 8 + lat);
    endfunction

    // timeline built from R3, R4, R5, R6, R11
    task automatic build(input int s, input int lat, input int h);
        int tt;
        int l = (lat == 0) ? 8 : lat;
        for (int i = 0; i < 64; i++) begin
            ev[i] = 0;
            ea[i] = 0;
        end
        tt = l + 1;
        for (int k = 0; k < BEATS; k++) begin
            int a = (s + k) % 64;
            if (k > 0 && a % 16 == 0) tt += h;
            for (int j = 0; j < h; j++) begin
                ev[tt] = 1;
                ea[tt] = a;
                tt++;
            end
        end
        tend = tt - 1;
    endtask

    task automatic run_burst(input int s, input logic [6:0] cfg, input logic [6:0] nxt, input bit poke);
        int  h     = cfg[3] ? 2 : 1;
        bit  early = cfg[4];
        bit  pol   = cfg[5];
        build(s, int'(cfg[2:0]), h);
        burst_start = 1'b1;
        burst_addr  = AW'(s);
        @(negedge clk);
        burst_start = 1'b0;
        for (int t = 1; t <= tend + 2; t++) begin
            bit v   = (t <= tend) ? ev[t][0] : 1'b0;
            bit act;
            if (t > tend)      act = 1'b0;
            else if (early)    act = (t + h <= tend) ? !ev[t + h][0] : 1'b0;
            else               act = !v;
            check(t > tend ? "R10 idle valid" : "R3/R5/R6/R11 valid", 32'(data_vld), 32'(v));
            check("R4 data", 32'(rd_data), v ? 32'(wordf(ea[t])) : 32'd0);
            check(early ? "R9/R7 wait" : "R8/R7 wait", 32'(wait_o), 32'(pol ? act : !act));
            if (t == 2) begin
                cfg_we    = 1'b1;
                cfg_wdata = nxt;
            end
            if (t == 3) begin
                cfg_we = 1'b0;
                check("R1 readback", 32'(cfg_rdata), 32'({1'b1, nxt[5:0]}));
            end
            if (poke && t == 4) begin
                burst_start = 1'b1;
                burst_addr  = AW'(s ^ 5);
            end
            if (t == 5) burst_start = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        int addrs [5] = '{0, 13, 15, 60, 9};
        repeat (3) @(negedge clk);
        // R1 reset value, R10 idle level with pol=0
        check("R1 reset cfg", 32'(cfg_rdata), 32'h42);
        check("R10 reset wait", 32'(wait_o), 32'd1);
        check("R10 reset valid", 32'(data_vld), 32'd0);
        check("R4 reset data", 32'(rd_data), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 idle wait", 32'(wait_o), 32'd1);
        // R2: write pol=1 while idle, pin must not move
        cfg_we = 1'b1;
        cfg_wdata = 7'h3F;
        @(negedge clk);
        cfg_we = 1'b0;
        check("R1 readback type bit", 32'(cfg_rdata), 32'h7F);
        repeat (2) @(negedge clk);
        check("R2 idle write ignored", 32'(wait_o), 32'd1);
        cfg_we = 1'b1;
        cfg_wdata = cfg_of(0);
        @(negedge clk);
        cfg_we = 1'b0;
        for (int n = 0; n < 160; n++) begin
            run_burst(addrs[(n / 32) % 5], cfg_of(n), cfg_of(n + 1), (n % 3) == 0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        #2000000;
        nerr++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule